// File: doc/BRIEF.md
# Multi-Queue FIFO Shared Read Port

This block is one read port shared by four independent FIFO queues of 18-bit words. Each queue has its own storage and pointers, and a simple write port can load any queue. The read side serves one queue at a time. A queue is chosen by strobing a 5-bit read address. The upper field of that address must match a static 3-bit device ID, so up to eight such blocks can share one address bus. The chosen queue stays selected until another valid selection is made.

The read side works in fall-through style. When the output register holds no valid word and the selected queue has data, the queue's head word drops into the register without waiting for a read. An active-low valid flag reports whether the register holds a live word. A queue change is pipelined. For two edges the port keeps serving the old queue. On the second edge after the selecting edge, the new queue's head is forced into the output register. A reader that keeps read enable high therefore receives a word on every edge across the change. If the new queue is empty, the valid flag goes high and the last old word stays in the register. An output enable only tristates the data bus and does not affect the pipeline.

Top module: `mqReadPort`

## Requirements
- R1: After reset, outValidN is 1, selErr is 0 and the output register holds zero.
- R2: A selection occurs on a rising edge with rdAddrEn high and rdAddr[4:2] equal to devId. The queue is rdAddr[1:0]. That queue keeps being read until another accepted selection takes over.
- R3: A strobe whose rdAddr[4:2] differs from devId changes nothing: no queue change, no output change and no selErr.
- R4: A selection is accepted only if it comes 3 or more edges after the previous accepted one. An earlier matching strobe is ignored and sets selErr, which stays 1 until reset.
- R5: When outValidN is 1 and the current queue is not empty, the queue's head word is loaded into the output register and outValidN goes low, whether or not rdEn is asserted.
- R6: When outValidN is low and rdEn is high, the edge loads the current queue's next word. If that queue is empty, outValidN goes high instead. When outValidN is low and rdEn is low, the output word holds.
- R7: On the selecting edge and the edge after it, reads still come from the old queue. On the second edge after selection, the new queue's head is loaded whatever rdEn is. With enough old data and rdEn held high, no edge in the change goes without a word.
- R8: If the newly selected queue is empty, outValidN goes high on that second edge and the output register keeps the last old word.
- R9: When outEn is low, dataOut is high-impedance. Words are still consumed and loaded into the output register.
- R10: Each queue returns its words in write order. Writes to any queue may happen while reads are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the read and write sides |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrQ | input | 2 | Queue to write |
| wrData | input | 18 | Word to write |
| rdEn | input | 1 | Read enable, active high |
| rdAddrEn | input | 1 | Selection strobe for the read address |
| rdAddr | input | 5 | Device field [4:2] and queue field [1:0] |
| devId | input | 3 | Static ID of this block |
| outEn | input | 1 | Drives dataOut when high, high-impedance when low |
| dataOut | output | 18 | Output register onto the bus |
| outValidN | output | 1 | Low when the output register holds a valid word |
| selErr | output | 1 | Sticky flag for a selection that came too early |

## Verification
The bench keeps rdEn high across a queue change and checks the word sequence edge by edge. A design that switched one edge early would drop an old word, and one that switched one edge late would insert a bubble or repeat a word. It strobes a second selection one edge after an accepted one. A design that lacks the spacing guard would jump to the wrong queue and leave selErr low. It also selects an empty queue. A faulty design would then either keep outValidN low or overwrite the held word. Further checks cover a strobe with the wrong ID, which must leave everything unchanged, and a read made while the bus is tristated, which must still advance the queue.

// File: rtl/mqPkg.sv
package mqPkg;
  // queue-field width of the read address; queue count follows from it
  parameter int unsigned MQ_QSEL_W   = 2;
  // edges from an accepted selection to the forced load of the new queue
  parameter int unsigned MQ_SW_EDGE  = 2;

  typedef struct packed {
    logic                 popEn;
    logic [MQ_QSEL_W-1:0] popQ;
    logic                 loadOut;
    logic                 dropValid;
  } mqStrobe_t;
endpackage

// File: rtl/mqData.sv
module mqData
  import mqPkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [MQ_QSEL_W-1:0] wrQ,
  input  logic [DATA_W-1:0]    wrData,
  input  mqStrobe_t            strb,
  output logic [(1<<MQ_QSEL_W)-1:0] emptyVec,
  output logic [DATA_W-1:0]    outWord,
  output logic                 outValid
);
  localparam int unsigned NUM_Q = 1 << MQ_QSEL_W;
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] headVec [NUM_Q];

  for (genvar q = 0; q < NUM_Q; q++) begin : gQueue
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  fill;
    logic              doWr, doRd;

    assign doWr = wrEn && (wrQ == MQ_QSEL_W'(q)) && (fill != CNT_W'(DEPTH));
    assign doRd = strb.popEn && (strb.popQ == MQ_QSEL_W'(q)) && (fill != '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill  <= '0;
      end else begin
        if (doWr) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
        if (doRd) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
        case ({doWr, doRd})
          2'b10:   fill <= fill + 1'b1;
          2'b01:   fill <= fill - 1'b1;
          default: fill <= fill;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (doWr) mem[wrPtr] <= wrData;
    end

    assign emptyVec[q] = (fill == '0);
    assign headVec[q]  = mem[rdPtr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      outValid <= 1'b0;
    end else if (strb.loadOut) begin
      outWord  <= headVec[strb.popQ];
      outValid <= 1'b1;
    end else if (strb.dropValid) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/mqCtrl.sv
module mqCtrl
  import mqPkg::*;
#(
  parameter int unsigned ID_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdEn,
  input  logic                       rdAddrEn,
  input  logic [ID_W+MQ_QSEL_W-1:0]  rdAddr,
  input  logic [ID_W-1:0]            devId,
  input  logic [(1<<MQ_QSEL_W)-1:0]  emptyVec,
  input  logic                       outValid,
  output mqStrobe_t                  strb,
  output logic                       selErr
);
  localparam int unsigned ADDR_W = ID_W + MQ_QSEL_W;
  localparam int unsigned SWC_W  = $clog2(MQ_SW_EDGE + 1);

  logic [MQ_QSEL_W-1:0] curQ, nextQ;
  logic [SWC_W-1:0]     swCnt;
  logic                 idHit, accept, early, switchNow;

  assign idHit     = rdAddrEn && (rdAddr[ADDR_W-1 -: ID_W] == devId);
  assign accept    = idHit && (swCnt == '0);
  assign early     = idHit && (swCnt != '0);
  assign switchNow = (swCnt == SWC_W'(1));

  always_comb begin
    strb = '0;
    if (switchNow) begin
      strb.popQ = nextQ;
      if (!emptyVec[nextQ]) begin
        strb.popEn   = 1'b1;
        strb.loadOut = 1'b1;
      end else begin
        strb.dropValid = 1'b1;
      end
    end else begin
      strb.popQ = curQ;
      if (!outValid || rdEn) begin
        if (!emptyVec[curQ]) begin
          strb.popEn   = 1'b1;
          strb.loadOut = 1'b1;
        end else begin
          strb.dropValid = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ   <= '0;
      nextQ  <= '0;
      swCnt  <= '0;
      selErr <= 1'b0;
    end else begin
      if (accept) begin
        nextQ <= rdAddr[MQ_QSEL_W-1:0];
        swCnt <= SWC_W'(MQ_SW_EDGE);
      end else if (swCnt != '0) begin
        swCnt <= swCnt - 1'b1;
      end
      if (switchNow) curQ <= nextQ;
      if (early) selErr <= 1'b1;
    end
  end
endmodule

// File: rtl/mqReadPort.sv
module mqReadPort
  import mqPkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ID_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [MQ_QSEL_W-1:0]      wrQ,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      rdEn,
  input  logic                      rdAddrEn,
  input  logic [ID_W+MQ_QSEL_W-1:0] rdAddr,
  input  logic [ID_W-1:0]           devId,
  input  logic                      outEn,
  output logic [DATA_W-1:0]         dataOut,
  output logic                      outValidN,
  output logic                      selErr
);
  localparam int unsigned NUM_Q = 1 << MQ_QSEL_W;

  mqStrobe_t         strb;
  logic [NUM_Q-1:0]  emptyVec;
  logic [DATA_W-1:0] outWord;
  logic              outValid;

  mqCtrl #(.ID_W(ID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddrEn(rdAddrEn),
    .rdAddr(rdAddr), .devId(devId), .emptyVec(emptyVec),
    .outValid(outValid), .strb(strb), .selErr(selErr)
  );

  mqData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrQ(wrQ), .wrData(wrData),
    .strb(strb), .emptyVec(emptyVec), .outWord(outWord), .outValid(outValid)
  );

  assign dataOut   = outEn ? outWord : {DATA_W{1'bz}};
  assign outValidN = !outValid;
endmodule

// File: rtl/mqReadPortChk.sv
module mqReadPortChk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned QSEL_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     rdEn,
  input logic                     rdAddrEn,
  input logic [ID_W+QSEL_W-1:0]   rdAddr,
  input logic [ID_W-1:0]          devId,
  input logic                     outValidN,
  input logic                     selErr,
  input logic [DATA_W-1:0]        outWord
);
  logic       hit;
  logic [1:0] sinceAcc, sinceHit;

  assign hit = rdAddrEn && (rdAddr[ID_W+QSEL_W-1 -: ID_W] == devId);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAcc <= 2'd3;
      sinceHit <= 2'd3;
    end else begin
      if (hit && sinceAcc == 2'd3) sinceAcc <= 2'd1;
      else if (sinceAcc != 2'd3)   sinceAcc <= sinceAcc + 2'd1;
      if (hit)                     sinceHit <= 2'd1;
      else if (sinceHit != 2'd3)   sinceHit <= sinceHit + 2'd1;
    end
  end

  // R4: a matching strobe inside the spacing window raises selErr
  a_r4_early_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hit && sinceAcc != 2'd3) |=> selErr);

  // R4: selErr stays set until reset
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);

  // R6: with a valid word, no read and no selection in flight, output holds
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!outValidN && !rdEn && !hit && sinceHit == 2'd3) |=> ($stable(outWord) && !outValidN));

  // R8: when the valid flag drops, the held word is left untouched
  a_r8_drop_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValidN) |-> $stable(outWord));
endmodule

bind mqReadPort mqReadPortChk #(.DATA_W(DATA_W), .ID_W(ID_W), .QSEL_W(mqPkg::MQ_QSEL_W)) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddrEn(rdAddrEn), .rdAddr(rdAddr),
  .devId(devId), .outValidN(outValidN), .selErr(selErr), .outWord(outWord)
);

// File: tb/mqReadPort_test.sv
module mqReadPort_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 18;

  logic clk = 1'b0;
  logic rstN, wrEn, rdEn, rdAddrEn, outEn;
  logic [1:0] wrQ;
  logic [DATA_W-1:0] wrData;
  logic [4:0] rdAddr;
  logic [2:0] devId;
  wire  [DATA_W-1:0] dataOut;
  wire  outValidN, selErr;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [DATA_W-1:0] expQ[$];

  always #(CLK_P/2) clk = ~clk;

  mqReadPort uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrQ(wrQ), .wrData(wrData),
    .rdEn(rdEn), .rdAddrEn(rdAddrEn), .rdAddr(rdAddr), .devId(devId),
    .outEn(outEn), .dataOut(dataOut), .outValidN(outValidN), .selErr(selErr)
  );

  function automatic logic [DATA_W-1:0] w(int q, int i);
    return {q[1:0], 16'(16'h0100 * (q + 1) + i)};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeWord(int q, int i);
    wrEn = 1'b1; wrQ = q[1:0]; wrData = w(q, i);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic sel(logic [2:0] id, int q);
    rdAddrEn = 1'b1; rdAddr = {id, q[1:0]};
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // monitor: a word is consumed on the next edge when read and valid
  always @(negedge clk) begin
    if (rstN === 1'b1 && rdEn && !outValidN) begin
      if (expQ.size() == 0) begin
        check(0, "R10 unexpected word", 32'(dataOut), 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = expQ.pop_front();
        if (outEn) check(dataOut == e, "R10 read order", 32'(dataOut), 32'(e));
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    rstN = 0; wrEn = 0; rdEn = 0; rdAddrEn = 0; outEn = 1;
    wrQ = 0; wrData = 0; rdAddr = 0; devId = 3'd5;
    repeat (3) tick();
    rstN = 1;
    @(negedge clk);
    check(outValidN == 1'b1, "R1 valid flag", 32'(outValidN), 1);
    check(selErr == 1'b0, "R1 selErr", 32'(selErr), 0);
    check(dataOut == '0, "R1 output register", 32'(dataOut), 0);

    foreach (expQ[k]) expQ.delete(k);
    for (int i = 0; i < 4; i++) expQ.push_back(w(0, i));
    for (int i = 0; i < 5; i++) expQ.push_back(w(1, i));
    for (int i = 0; i < 4; i++) expQ.push_back(w(2, i));
    for (int i = 0; i < 2; i++) expQ.push_back(w(3, i));
    for (int i = 4; i < 6; i++) expQ.push_back(w(0, i));

    tick();
    for (int q = 0; q < 3; q++)
      for (int i = 0; i < 6; i++) writeWord(q, i);
    repeat (2) tick();
    @(negedge clk);
    check(!outValidN, "R5 fall-through valid", 32'(outValidN), 0);
    check(dataOut == w(0, 0), "R5 fall-through word", 32'(dataOut), 32'(w(0, 0)));

    // R9: tristate, yet the pipeline still advances
    outEn = 0;
    @(negedge clk);
    check(dataOut === {DATA_W{1'bz}}, "R9 high-Z", 32'(dataOut), 0);
    tick(); rdEn = 1; tick(); rdEn = 0; outEn = 1;
    repeat (2) tick();
    @(negedge clk);
    check(dataOut == w(0, 1), "R9 load under tristate / R6 hold", 32'(dataOut), 32'(w(0, 1)));

    // R7: switch q0 -> q1 with continuous reads
    rdEn = 1; sel(devId, 1);
    tick(); rdAddrEn = 0;
    @(negedge clk);
    check(dataOut == w(0, 2), "R7 old queue on edge 0", 32'(dataOut), 32'(w(0, 2)));
    tick();
    @(negedge clk);
    check(dataOut == w(0, 3) && !outValidN, "R7 old queue on edge 1", 32'(dataOut), 32'(w(0, 3)));
    tick();
    @(negedge clk);
    check(dataOut == w(1, 0) && !outValidN, "R7 new head on edge 2", 32'(dataOut), 32'(w(1, 0)));
    tick(); tick(); rdEn = 0;
    @(negedge clk);
    check(dataOut == w(1, 2), "R2 sticky queue", 32'(dataOut), 32'(w(1, 2)));

    // R3: wrong device ID
    sel(devId ^ 3'b001, 3);
    tick(); rdAddrEn = 0;
    repeat (3) tick();
    @(negedge clk);
    check(dataOut == w(1, 2) && !outValidN, "R3 mismatch ignored", 32'(dataOut), 32'(w(1, 2)));
    check(selErr == 1'b0, "R3 no error", 32'(selErr), 0);

    // R4: second selection one edge after the first
    rdEn = 1; sel(devId, 2);
    tick(); sel(devId, 3);
    tick(); rdAddrEn = 0;
    @(negedge clk);
    check(selErr == 1'b1, "R4 early flag", 32'(selErr), 1);
    tick();
    @(negedge clk);
    check(dataOut == w(2, 0), "R4 early one dropped", 32'(dataOut), 32'(w(2, 0)));
    tick();
    @(negedge clk);
    check(dataOut == w(2, 1), "R4 still on q2", 32'(dataOut), 32'(w(2, 1)));

    // R8: select empty q3
    sel(devId, 3);
    tick(); rdAddrEn = 0;
    tick(); tick();
    @(negedge clk);
    check(outValidN == 1'b1, "R8 valid drops", 32'(outValidN), 1);
    check(dataOut == w(2, 3), "R8 word held", 32'(dataOut), 32'(w(2, 3)));
    repeat (2) tick();
    @(negedge clk);
    check(outValidN == 1'b1 && dataOut == w(2, 3), "R8 stays empty", 32'(dataOut), 32'(w(2, 3)));
    check(selErr == 1'b1, "R4 sticky", 32'(selErr), 1);

    // R10/R5: write into the selected empty queue
    rdEn = 0;
    writeWord(3, 0);
    repeat (2) tick();
    @(negedge clk);
    check(!outValidN && dataOut == w(3, 0), "R5 R10 fall-through after write", 32'(dataOut), 32'(w(3, 0)));
    writeWord(3, 1);
    tick();
    rdEn = 1; tick();
    sel(devId, 0);
    tick(); rdAddrEn = 0;
    @(negedge clk);
    check(outValidN == 1'b1, "R6 empty after read", 32'(outValidN), 1);
    tick(); tick();
    @(negedge clk);
    check(!outValidN && dataOut == w(0, 4), "R2 R7 back to q0", 32'(dataOut), 32'(w(0, 4)));
    tick(); tick(); rdEn = 0;
    @(negedge clk);
    check(outValidN == 1'b1, "R6 drained", 32'(outValidN), 1);
    check(expQ.size() == 0, "R10 all words seen", 32'(expQ.size()), 0);

    done = 1;
    summary();
  end
endmodule